// File: doc/BRIEF.md
# SCSI Selection Qualifier

This block sits beside a SCSI target's bus interface and decides whether a bus-initiated selection (or reselection) is meant for it. It watches the 16 active-low data lines, the two per-byte parity lines and the SEL and BSY control lines. It waits until the bus shows a selection that has settled. It then judges the ID bits on the bus against the target's own ID and three static configuration bits.

When the selection qualifies, the block emits a single-cycle `selectedPulse` and latches the initiator's ID. When the only reason for refusal is bad parity, it emits a single-cycle `parityErr` instead. One configuration bit refuses selections that show only the target's own ID bit, so that a single flipped bus line cannot look like an old-style single-initiator selection. Another declares every device on the bus 16 bits wide. With parity checking on, that bit adds the upper-byte parity check, which an 8-bit initiator cannot satisfy.

Top module: `scsi_sel_qualifier`

## Requirements
- R1: Data and parity lines are active low; ID bit n is asserted when `busDataN[n]` is 0. No selection is accepted unless the bit at index `ownId` is asserted.
- R2: A selection is evaluated only while `selN`=0 and `bsyN`=1, and only once all sampled lines (data, parity, SEL, BSY) have held the same value across two consecutive rising edges. For lines applied just before edge k and held, `selectedPulse` is high in the cycle after edge k+2 and low in the cycles before it. Exactly one evaluation is made per selection, and the block re-arms only after SEL is released or BSY asserted.
- R3: With exactly two ID bits asserted, one of them own, the selection is accepted and `initiatorId` takes the index of the other bit.
- R4: With more than two ID bits asserted, the selection is refused with neither `selectedPulse` nor `parityErr`.
- R5: With only the own bit asserted and `cfgNoSingle`=0, the selection is accepted and `initiatorId` takes the value of `ownId`.
- R6: With `cfgNoSingle`=1, a selection showing only the own bit is ignored: no pulse, no parity error, and `initiatorId` unchanged.
- R7: With `cfgParEn`=1, the low byte must have odd parity over ID bits 7..0 plus the true (inverted) value of `busParN[0]`.
- R8: With `cfgParEn`=1 and `cfgWide`=1, the high byte must also have odd parity over ID bits 15..8 plus the true value of `busParN[1]`. An 8-bit initiator, which leaves data lines 15..8 and `busParN[1]` released high, therefore gets a parity error and is not selected.
- R9: With `cfgWide`=0, data lines 15..8 and `busParN[1]` play no part in ID decoding or parity.
- R10: `parityErr` pulses for one cycle, at the same time a pulse would have come, exactly when the selection is otherwise acceptable but fails a parity check. `selectedPulse` and `parityErr` are never high together.
- R11: While `rst_n` is low, `selectedPulse`, `parityErr` and `initiatorId` are 0.
- R12: With `cfgParEn`=0, the parity lines have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busDataN | input | 16 | SCSI data lines, active low |
| busParN | input | 2 | Parity lines, bit 0 low byte, bit 1 high byte, active low |
| selN | input | 1 | SEL line, active low |
| bsyN | input | 1 | BSY line, active low |
| ownId | input | 4 | Target's own SCSI ID |
| cfgNoSingle | input | 1 | Refuse selections carrying only the own ID bit |
| cfgWide | input | 1 | Every device on the bus is 16 bits wide |
| cfgParEn | input | 1 | Enable parity checking |
| selectedPulse | output | 1 | One-cycle pulse on an accepted selection |
| initiatorId | output | 4 | ID of the last accepted initiator |
| parityErr | output | 1 | One-cycle pulse when refusal is due only to parity |

## Verification
Every result of this block lands at a fixed point: two register stages settle the lines, and one more edge registers the verdict. For lines driven just before rising edge k and then held, both pulses and the initiator ID are due just after edge k+2. The bench drives on falling edges and samples on falling edges. It checks that nothing appears after edge k+1, that the verdict is present after edge k+2, and that the pulses have cleared again after edge k+3. Between trials the bus is released for two edges so that the next trial starts from an idle, re-armed state.

// File: rtl/scsi_selq_pkg.sv
package scsi_selq_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic evalNow;   // judge the settled bus this cycle
  } ctrlStrobe_t;

  // observations from the datapath back to the control FSM
  typedef struct packed {
    logic busActive;    // SEL asserted, BSY released in the latest sample
    logic windowReady;  // busActive and every line unchanged over two samples
  } dpStatus_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } qualState_t;

endpackage

// File: rtl/sel_qual_decode.sv
module sel_qual_decode #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int ID_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] idBits,     // already inverted: 1 = asserted
  input  logic [LANES-1:0]  parTrue,    // already inverted parity lines
  input  logic [ID_W-1:0]   ownId,
  input  logic              cfgNoSingle,
  input  logic              cfgWide,
  input  logic              cfgParEn,
  output logic              structOk,
  output logic              parOk,
  output logic [ID_W-1:0]   initIdx
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [LANES-1:0]  laneOn;
  logic [LANES-1:0]  lanePass;
  logic [DATA_W-1:0] idMask;
  logic [DATA_W-1:0] liveIds;
  logic [DATA_W-1:0] otherIds;
  logic [CNT_W-1:0]  idCount;
  logic              ownHit;
  logic [ID_W-1:0]   otherIdx;

  // lane 0 is always on the bus; wider lanes only in a 16-bit system
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_base
      assign laneOn[l] = 1'b1;
    end else begin : g_upper
      assign laneOn[l] = cfgWide;
    end
    assign idMask[l*LANE_W +: LANE_W] = {LANE_W{laneOn[l]}};
    // odd parity over the lane's ID bits and its parity bit
    assign lanePass[l] = ^{idBits[l*LANE_W +: LANE_W], parTrue[l]};
  end

  assign liveIds  = idBits & idMask;
  assign ownHit   = liveIds[ownId];
  assign otherIds = liveIds & ~(DATA_W'(1) << ownId);

  always_comb begin
    idCount = '0;
    for (int b = 0; b < DATA_W; b++) begin
      idCount = idCount + CNT_W'(liveIds[b]);
    end
  end

  always_comb begin
    otherIdx = '0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      if (otherIds[b]) otherIdx = ID_W'(b);
    end
  end

  assign structOk = ownHit &&
                    ((idCount == CNT_W'(2)) ||
                     ((idCount == CNT_W'(1)) && !cfgNoSingle));

  assign parOk   = !cfgParEn || (&(lanePass | ~laneOn));
  assign initIdx = (idCount == CNT_W'(2)) ? otherIdx : ownId;

endmodule

// File: rtl/sel_qual_dp.sv
module sel_qual_dp
  import scsi_selq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int ID_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] busDataN,
  input  logic [LANES-1:0]  busParN,
  input  logic              selN,
  input  logic              bsyN,
  input  logic [ID_W-1:0]   ownId,
  input  logic              cfgNoSingle,
  input  logic              cfgWide,
  input  logic              cfgParEn,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic              selectedPulse,
  output logic [ID_W-1:0]   initiatorId,
  output logic              parityErr
);

  // two sample stages: the newer one is judged, the older one proves stability
  logic [DATA_W-1:0] dataNew, dataOld;
  logic [LANES-1:0]  parNew, parOld;
  logic              selNew, selOld, bsyNew, bsyOld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataNew <= '1;
      dataOld <= '1;
      parNew  <= '1;
      parOld  <= '1;
      selNew  <= 1'b1;
      selOld  <= 1'b1;
      bsyNew  <= 1'b1;
      bsyOld  <= 1'b1;
    end else begin
      dataNew <= busDataN;
      dataOld <= dataNew;
      parNew  <= busParN;
      parOld  <= parNew;
      selNew  <= selN;
      selOld  <= selNew;
      bsyNew  <= bsyN;
      bsyOld  <= bsyNew;
    end
  end

  logic linesSteady;
  assign linesSteady = (dataNew == dataOld) && (parNew == parOld) &&
                       (selNew == selOld) && (bsyNew == bsyOld);

  assign status.busActive   = !selNew && bsyNew;
  assign status.windowReady = status.busActive && linesSteady;

  logic            structOk, parOk;
  logic [ID_W-1:0] initIdx;

  sel_qual_decode #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) decode_i (
    .idBits      (~dataNew),
    .parTrue     (~parNew),
    .ownId       (ownId),
    .cfgNoSingle (cfgNoSingle),
    .cfgWide     (cfgWide),
    .cfgParEn    (cfgParEn),
    .structOk    (structOk),
    .parOk       (parOk),
    .initIdx     (initIdx)
  );

  logic acceptNow, parFailNow;
  assign acceptNow  = strobe.evalNow && structOk && parOk;
  assign parFailNow = strobe.evalNow && structOk && !parOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selectedPulse <= 1'b0;
      parityErr     <= 1'b0;
      initiatorId   <= '0;
    end else begin
      selectedPulse <= acceptNow;
      parityErr     <= parFailNow;
      if (acceptNow) initiatorId <= initIdx;
    end
  end

endmodule

// File: rtl/sel_qual_ctrl.sv
module sel_qual_ctrl
  import scsi_selq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);

  qualState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.evalNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (status.windowReady) begin
          strobe.evalNow = 1'b1;
          stateNext      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        // stay quiet until the selection is over
        if (!status.busActive) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

endmodule

// File: rtl/scsi_sel_qualifier.sv
module scsi_sel_qualifier
  import scsi_selq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int ID_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] busDataN,
  input  logic [LANES-1:0]  busParN,
  input  logic              selN,
  input  logic              bsyN,
  input  logic [ID_W-1:0]   ownId,
  input  logic              cfgNoSingle,
  input  logic              cfgWide,
  input  logic              cfgParEn,
  output logic              selectedPulse,
  output logic [ID_W-1:0]   initiatorId,
  output logic              parityErr
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  sel_qual_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .strobe (strobe)
  );

  sel_qual_dp #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busDataN      (busDataN),
    .busParN       (busParN),
    .selN          (selN),
    .bsyN          (bsyN),
    .ownId         (ownId),
    .cfgNoSingle   (cfgNoSingle),
    .cfgWide       (cfgWide),
    .cfgParEn      (cfgParEn),
    .strobe        (strobe),
    .status        (status),
    .selectedPulse (selectedPulse),
    .initiatorId   (initiatorId),
    .parityErr     (parityErr)
  );

endmodule

// File: rtl/scsi_sel_qualifier_chk.sv
module scsi_sel_qualifier_chk #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int ID_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] busDataN,
  input logic [LANES-1:0]  busParN,
  input logic              selN,
  input logic              bsyN,
  input logic [ID_W-1:0]   ownId,
  input logic              cfgNoSingle,
  input logic              cfgWide,
  input logic              cfgParEn,
  input logic              selectedPulse,
  input logic [ID_W-1:0]   initiatorId,
  input logic              parityErr
);

  logic [DATA_W-1:0] seenIds;
  logic [DATA_W-1:0] seenMask;
  logic [7:0]        seenCount;
  logic              seenOwn;
  logic              seenLowOk;
  logic              seenAllOk;

  always_comb begin
    seenMask = '0;
    seenMask[LANE_W-1:0] = '1;
    if (cfgWide) seenMask = '1;
    seenIds   = ~busDataN & seenMask;
    seenOwn   = seenIds[ownId];
    seenCount = '0;
    for (int b = 0; b < DATA_W; b++) seenCount = seenCount + 8'(seenIds[b]);
    seenLowOk = ^{~busDataN[LANE_W-1:0], ~busParN[0]};
    seenAllOk = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      seenAllOk = seenAllOk && (^{~busDataN[l*LANE_W +: LANE_W], ~busParN[l]});
    end
  end

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    selectedPulse |=> !selectedPulse);

  p_settled_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    selectedPulse |-> ($past(!selN && bsyN, 2) && $past(!selN && bsyN, 1) &&
                       ($past(busDataN, 1) == $past(busDataN, 2)) &&
                       ($past(busParN, 1) == $past(busParN, 2))));

  p_own_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    selectedPulse |-> $past(seenOwn, 2));

  p_at_most_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    selectedPulse |-> ($past(seenCount, 2) <= 8'd2));

  p_no_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (selectedPulse && $past(cfgNoSingle, 2)) |-> ($past(seenCount, 2) == 8'd2));

  p_low_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (selectedPulse && $past(cfgParEn, 2)) |-> $past(seenLowOk, 2));

  p_wide_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (selectedPulse && $past(cfgParEn && cfgWide, 2)) |-> $past(seenAllOk, 2));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(selectedPulse && parityErr));

  p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    parityErr |=> !parityErr);

  p_err_needs_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    parityErr |-> $past(cfgParEn, 2));

  p_id_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !selectedPulse |-> $stable(initiatorId));

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r11: assert (!selectedPulse && !parityErr && (initiatorId == '0));
    end
  end

endmodule

bind scsi_sel_qualifier scsi_sel_qualifier_chk #(
  .DATA_W (DATA_W),
  .LANE_W (LANE_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .busDataN      (busDataN),
  .busParN       (busParN),
  .selN          (selN),
  .bsyN          (bsyN),
  .ownId         (ownId),
  .cfgNoSingle   (cfgNoSingle),
  .cfgWide       (cfgWide),
  .cfgParEn      (cfgParEn),
  .selectedPulse (selectedPulse),
  .initiatorId   (initiatorId),
  .parityErr     (parityErr)
);

// File: tb/scsi_sel_qualifier_tb.sv
module scsi_sel_qualifier_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] busDataN = 16'hFFFF;
  logic [1:0]  busParN = 2'b11;
  logic        selN = 1'b1;
  logic        bsyN = 1'b1;
  logic [3:0]  ownId = 4'd0;
  logic        cfgNoSingle = 1'b0;
  logic        cfgWide = 1'b0;
  logic        cfgParEn = 1'b0;
  logic        selectedPulse;
  logic [3:0]  initiatorId;
  logic        parityErr;

  int checks = 0;
  int errors = 0;
  logic [3:0] expInit = 4'd0;

  always #4 clk = ~clk;

  scsi_sel_qualifier dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busDataN      (busDataN),
    .busParN       (busParN),
    .selN          (selN),
    .bsyN          (bsyN),
    .ownId         (ownId),
    .cfgNoSingle   (cfgNoSingle),
    .cfgWide       (cfgWide),
    .cfgParEn      (cfgParEn),
    .selectedPulse (selectedPulse),
    .initiatorId   (initiatorId),
    .parityErr     (parityErr)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic releaseBus();
    selN = 1'b1; bsyN = 1'b1; busDataN = 16'hFFFF; busParN = 2'b11;
    tick(); tick();
  endtask

  // parity line values (active low) that make each byte odd
  function automatic logic [1:0] goodPar(input logic [15:0] ids);
    return {^ids[15:8], ^ids[7:0]};
  endfunction

  // one selection attempt; mode 0 good parity, 1 bad low parity,
  // 2 narrow initiator (upper lines and upper parity left released)
  task automatic runTrial(input logic [3:0] own, input int cfg,
                          input logic [15:0] idsIn, input int mode);
    logic [15:0] ids, mask, live;
    logic [1:0]  parN;
    int cnt, other;
    logic wide, parEn, noSingle, ownHit, structOk, loOk, hiOk, parOk, expSel, expErr;
    string tag;
    noSingle = cfg[0]; wide = cfg[1]; parEn = cfg[2];
    ids  = idsIn;
    if (mode == 2) ids[15:8] = 8'h00;
    parN = goodPar(ids);
    if (mode == 1) parN[0] = ~parN[0];
    if (mode == 2) parN[1] = 1'b1;
    mask = wide ? 16'hFFFF : 16'h00FF;
    live = ids & mask;
    cnt = 0; other = own;
    for (int b = 0; b < 16; b++) begin
      if (live[b]) begin
        cnt++;
        if (b != own) other = b;
      end
    end
    ownHit   = live[own];
    structOk = ownHit && (cnt == 2 || (cnt == 1 && !noSingle));
    loOk  = ^{ids[7:0], ~parN[0]};
    hiOk  = ^{ids[15:8], ~parN[1]};
    parOk = !parEn || (loOk && (!wide || hiOk));
    expSel = structOk && parOk;
    expErr = structOk && !parOk;
    if (cnt > 2) tag = "R4";
    else if (!wide && (ids[15:8] != 0)) tag = "R9";
    else if (!parEn && mode != 0) tag = "R12";
    else if (expErr && mode == 2) tag = "R8";
    else if (expErr) tag = "R7";
    else if (!ownHit) tag = "R1";
    else if (cnt == 1) tag = noSingle ? "R6" : "R5";
    else tag = "R3";

    ownId = own; cfgNoSingle = noSingle; cfgWide = wide; cfgParEn = parEn;
    busDataN = ~ids; busParN = parN; selN = 1'b0; bsyN = 1'b1;
    tick();  // edge k
    tick();  // edge k+1
    chk({tag, " R2 early"}, selectedPulse, 0);
    tick();  // edge k+2: verdict due
    chk({tag, " sel"}, selectedPulse, expSel);
    chk({tag, " R10 perr"}, parityErr, expErr);
    if (expSel) expInit = (cnt == 2) ? 4'(other) : own;
    chk({tag, " id"}, initiatorId, expInit);
    tick();
    chk("R2 sel one cycle", selectedPulse, 0);
    chk("R10 perr one cycle", parityErr, 0);
    releaseBus();
  endtask

  initial begin
    repeat (3) tick();
    chk("R11 sel", selectedPulse, 0);
    chk("R11 perr", parityErr, 0);
    chk("R11 id", initiatorId, 0);
    rst_n = 1'b1;
    tick(); tick();

    // R2: lines moving every cycle are not judged until they settle
    ownId = 4'd5; cfgNoSingle = 1'b0; cfgWide = 1'b0; cfgParEn = 1'b0;
    selN = 1'b0; bsyN = 1'b1; busParN = 2'b11;
    busDataN = ~16'h0022; tick(); chk("R2 moving", selectedPulse, 0);
    busDataN = ~16'h0024; tick(); chk("R2 moving", selectedPulse, 0);
    busDataN = ~16'h0028; tick(); chk("R2 moving", selectedPulse, 0);
    tick(); chk("R2 settling", selectedPulse, 0);
    tick(); chk("R2 settled", selectedPulse, 1);
    chk("R3 id after settle", initiatorId, 3);
    expInit = 4'd3;
    // R2: long hold gives no second pulse
    for (int c = 0; c < 6; c++) begin
      tick(); chk("R2 long hold", selectedPulse, 0);
    end
    releaseBus();

    // R2: BSY asserted blocks evaluation
    busDataN = ~16'h0021; bsyN = 1'b0; selN = 1'b0;
    for (int c = 0; c < 5; c++) begin
      tick(); chk("R2 busy", selectedPulse, 0);
    end
    releaseBus();

    // sweep: two own IDs, all configs, every pair or single bit, three parity modes
    for (int o = 0; o < 2; o++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        for (int i = 0; i < 16; i++) begin
          for (int j = i; j < 16; j++) begin
            for (int m = 0; m < 3; m++) begin
              runTrial((o == 0) ? 4'd2 : 4'd11, cfg,
                       (16'h1 << i) | (16'h1 << j), m);
            end
          end
        end
      end
    end

    // R4: three asserted bits, own included
    for (int i = 1; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        runTrial(4'd0, 2, 16'h0001 | (16'h1 << i) | (16'h1 << j), 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule